// File: doc/BRIEF.md
# SPI Slave Hold Pause Controller

This block gives an SPI slave a pause input. While the slave is selected, the bus master can drive the active-low hold line low to freeze the transaction in progress without deselecting the device. The block watches the hold line, the serial clock and the chip select, all sampled by a fast system clock. It produces a `hold_active` flag that gates the slave's shift enable and forces its serial-output enable off. The slave's bit and byte counters advance only on the gated shift enable, so they keep their values across a pause and the transfer resumes at the exact bit where it stopped.

Entry into and exit from the pause are qualified by the serial clock level. A hold edge is acted on only while SCK is low. An edge that arrives while SCK is high waits in a pending state until SCK next reads low. Deselecting the device during a pause ends it at once and emits a one-cycle abort pulse, which the slave uses to clear its transaction state. After that the flag stays clear whatever the hold level is.

The controller is a four-state machine. `ST_RUN` means not paused. `ST_ENTER_WAIT` means a hold fall was seen while SCK was high. `ST_HELD` means paused. `ST_EXIT_WAIT` means hold has risen while SCK is high and the block is still paused. The transitions are:
- run→held on a selected hold fall with SCK low;
- run→enter_wait on the same fall with SCK high;
- enter_wait→held when SCK goes low;
- enter_wait→run when hold rises first (the pause is cancelled);
- held→run when hold is high with SCK low;
- held→exit_wait when hold is high with SCK high;
- exit_wait→run when SCK goes low;
- exit_wait→held when hold falls again;
- any state→run when chip select is high.

Top module: `spi_hold_ctrl`

## Requirements
- R1: After reset `hold_active` and `hold_abort` are 0, and `so_oe_o`/`shift_en_o` follow their inputs.
- R2: A falling edge on `hold_n` while `cs_n` is low and `sck` is low sets `hold_active` exactly SYNC_STAGES+1 clock cycles after the edge is driven.
- R3: A falling edge on `hold_n` seen while `sck` is high does not set `hold_active`. The pause begins only once `sck` is seen low.
- R4: With `hold_active` set, `hold_n` high and `sck` low clear `hold_active` (SYNC_STAGES+1 cycles of latency).
- R5: A rising `hold_n` seen while `sck` is high leaves `hold_active` set until `sck` is seen low.
- R6: While `hold_active` is 1, `so_oe_o` and `shift_en_o` are 0. Otherwise they equal `so_oe_i` and `shift_en_i` in the same cycle.
- R7: While selected with `hold_n` low, a set `hold_active` stays set whatever `sck` does.
- R8: `cs_n` high clears `hold_active`. If it was set, `hold_abort` pulses for exactly one cycle, in the same cycle `hold_active` clears. The flag then stays clear while deselected, even with `hold_n` low.
- R9: A pause needs a falling edge of `hold_n` while selected. A `hold_n` that is already low when `cs_n` falls, or that falls while deselected, does not set `hold_active`.
- R10: A pending entry is cancelled if `hold_n` rises again before `sck` is seen low.
- R11: A pending exit is cancelled if `hold_n` falls again before `sck` is seen low, and `hold_active` remains 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low synchronous reset |
| hold_n | input | 1 | Active-low pause request from the bus master |
| sck | input | 1 | Serial clock pin level |
| cs_n | input | 1 | Active-low chip select |
| so_oe_i | input | OE_W | Serial-output enable request from the slave core |
| shift_en_i | input | 1 | Shift/count enable request from the slave core |
| hold_active | output | 1 | Pause in force |
| hold_abort | output | 1 | One-cycle pulse: deselected while paused |
| shift_en_o | output | 1 | Gated shift enable |
| so_oe_o | output | OE_W | Gated serial-output enable |

## Verification
Directed sequences cover the following cases:
- a hold fall with SCK low, to check the exact entry latency;
- a hold fall with SCK high, which separates immediate from deferred entry;
- a hold rise with SCK high, then with SCK low, which separates deferred from immediate exit;
- short hold pulses that cancel a pending entry or a pending exit;
- a deselect during a pause, which checks the abort pulse cycle;
- hold already low at select time, which separates an edge-triggered entry from a level-triggered one.

A long run then drives random SCK toggling, rare hold and chip-select changes, and random enable requests. A bench reference model, built from the state rules, checks the flag, the abort pulse and both gated enables on every cycle.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;

    typedef enum logic [1:0] {
        ST_RUN        = 2'd0,
        ST_ENTER_WAIT = 2'd1,
        ST_HELD       = 2'd2,
        ST_EXIT_WAIT  = 2'd3
    } hold_state_t;

endpackage

// File: rtl/hold_sync.sv
module hold_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] pipe;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe <= {STAGES{RST_VAL}};
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                pipe[i] <= pipe[i-1];
            end
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/hold_fsm.sv
module hold_fsm
    import spi_hold_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hold_s,   // synced hold_n (0 = pause requested)
    input  logic sck_s,    // synced serial clock level
    input  logic cs_s,     // synced cs_n (1 = deselected)
    output logic hold_active,
    output logic hold_abort
);
    hold_state_t state, nxt;
    logic        hold_prev;
    logic        hold_fall;
    logic        abort_q;

    assign hold_fall = hold_prev & ~hold_s;

    // next-state logic
    always_comb begin
        nxt = state;
        if (cs_s) begin
            nxt = ST_RUN;
        end else begin
            unique case (state)
                ST_RUN: begin
                    if (hold_fall) nxt = sck_s ? ST_ENTER_WAIT : ST_HELD;
                end
                ST_ENTER_WAIT: begin
                    if (hold_s)      nxt = ST_RUN;
                    else if (!sck_s) nxt = ST_HELD;
                end
                ST_HELD: begin
                    if (hold_s) nxt = sck_s ? ST_EXIT_WAIT : ST_RUN;
                end
                ST_EXIT_WAIT: begin
                    if (!hold_s)     nxt = ST_HELD;
                    else if (!sck_s) nxt = ST_RUN;
                end
                default: nxt = ST_RUN;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_RUN;
            hold_prev <= 1'b1;
        end else begin
            state     <= nxt;
            hold_prev <= hold_s;
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) abort_q <= 1'b0;
        else        abort_q <= cs_s && (state == ST_HELD || state == ST_EXIT_WAIT);
    end

    assign hold_active = (state == ST_HELD) || (state == ST_EXIT_WAIT);
    assign hold_abort  = abort_q;

    // R2
    entry_sck_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_active) |-> $past(!sck_s));
    // R9
    entry_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_active) |-> $past(!cs_s));
    // R5
    exit_sck_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold_active) |-> ($past(!sck_s) || $past(cs_s)));
    // R7
    hold_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_active && !hold_s && !cs_s) |=> hold_active);
    // R8
    deselect_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> !hold_active);
    // R8
    abort_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_abort |=> !hold_abort);
    // R8
    abort_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_abort |-> !hold_active);
endmodule

// File: rtl/hold_gate.sv
module hold_gate #(
    parameter int OE_W = 1
) (
    input  logic            hold_active,
    input  logic [OE_W-1:0] so_oe_i,
    input  logic            shift_en_i,
    output logic [OE_W-1:0] so_oe_o,
    output logic            shift_en_o
);
    for (genvar g = 0; g < OE_W; g++) begin : g_lane
        assign so_oe_o[g] = so_oe_i[g] & ~hold_active;
    end

    assign shift_en_o = shift_en_i & ~hold_active;
endmodule

// File: rtl/spi_hold_ctrl.sv
module spi_hold_ctrl #(
    parameter int SYNC_STAGES = 2,
    parameter int OE_W        = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hold_n,
    input  logic            sck,
    input  logic            cs_n,
    input  logic [OE_W-1:0] so_oe_i,
    input  logic            shift_en_i,
    output logic            hold_active,
    output logic            hold_abort,
    output logic            shift_en_o,
    output logic [OE_W-1:0] so_oe_o
);
    logic hold_s, sck_s, cs_s;

    hold_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_hold (
        .clk(clk), .rst_n(rst_n), .d(hold_n), .q(hold_s));
    hold_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sck (
        .clk(clk), .rst_n(rst_n), .d(sck), .q(sck_s));
    hold_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cs (
        .clk(clk), .rst_n(rst_n), .d(cs_n), .q(cs_s));

    hold_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .hold_s(hold_s), .sck_s(sck_s), .cs_s(cs_s),
        .hold_active(hold_active), .hold_abort(hold_abort));

    hold_gate #(.OE_W(OE_W)) u_gate (
        .hold_active(hold_active), .so_oe_i(so_oe_i), .shift_en_i(shift_en_i),
        .so_oe_o(so_oe_o), .shift_en_o(shift_en_o));

    // R6
    gate_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_active |-> (so_oe_o == '0 && !shift_en_o));
endmodule

// File: tb/spi_hold_ctrl_tb_top.sv
module spi_hold_ctrl_tb_top;
    localparam int SYNC = 2;
    localparam int LAT  = SYNC + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hold_n = 1'b1, sck = 1'b0, cs_n = 1'b1;
    logic [0:0] so_oe_i = 1'b0;
    logic shift_en_i = 1'b0;
    logic hold_active, hold_abort, shift_en_o;
    logic [0:0] so_oe_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    spi_hold_ctrl #(.SYNC_STAGES(SYNC), .OE_W(1)) dut_i (
        .clk(clk), .rst_n(rst_n), .hold_n(hold_n), .sck(sck), .cs_n(cs_n),
        .so_oe_i(so_oe_i), .shift_en_i(shift_en_i),
        .hold_active(hold_active), .hold_abort(hold_abort),
        .shift_en_o(shift_en_o), .so_oe_o(so_oe_o));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // reference model built from the state rules
    logic [SYNC-1:0] m_h, m_s, m_c;
    logic m_prev, m_ab;
    int   m_st;

    function automatic int next_st(int st, logic h, logic s, logic c, logic fall);
        if (c) return 0;
        case (st)
            0: return fall ? (s ? 1 : 2) : 0;
            1: return h ? 0 : (!s ? 2 : 1);
            2: return h ? (s ? 3 : 0) : 2;
            default: return !h ? 2 : (!s ? 0 : 3);
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_h <= '1; m_s <= '0; m_c <= '1;
            m_prev <= 1'b1; m_st <= 0; m_ab <= 1'b0;
        end else begin
            m_h <= {m_h[SYNC-2:0], hold_n};
            m_s <= {m_s[SYNC-2:0], sck};
            m_c <= {m_c[SYNC-2:0], cs_n};
            m_prev <= m_h[SYNC-1];
            m_ab <= m_c[SYNC-1] && (m_st >= 2);
            m_st <= next_st(m_st, m_h[SYNC-1], m_s[SYNC-1], m_c[SYNC-1],
                             m_prev & ~m_h[SYNC-1]);
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic ha;
            ha = (m_st >= 2);
            chk(hold_active == ha, "R2/R3/R4/R5/R7 model flag", hold_active, ha);
            chk(hold_abort == m_ab, "R8 model abort", hold_abort, m_ab);
            chk(so_oe_o == (ha ? 1'b0 : so_oe_i), "R6 model so_oe", so_oe_o, ha ? 0 : so_oe_i);
            chk(shift_en_o == (ha ? 1'b0 : shift_en_i), "R6 model shift", shift_en_o, ha ? 0 : shift_en_i);
        end
    end

    task automatic drive(input logic h, input logic s, input logic c);
        @(negedge clk); #1;
        hold_n = h; sck = s; cs_n = c;
    endtask

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_report();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        finish_report();
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        #1 rst_n = 1'b1; so_oe_i = 1'b1; shift_en_i = 1'b1;
        waitn(1);
        // R1 reset state
        chk(hold_active == 0, "R1 flag", hold_active, 0);
        chk(hold_abort == 0, "R1 abort", hold_abort, 0);
        chk(so_oe_o == 1 && shift_en_o == 1, "R1 pass-through", so_oe_o, 1);

        drive(1, 0, 0); waitn(LAT + 1);
        // R2 entry with exact latency
        drive(0, 0, 0); waitn(LAT - 1);
        chk(hold_active == 0, "R2 before latency", hold_active, 0);
        waitn(1);
        chk(hold_active == 1, "R2 entry", hold_active, 1);
        chk(so_oe_o == 0 && shift_en_o == 0, "R6 gated off", so_oe_o, 0);
        // R7 sck toggles while held
        for (int i = 0; i < 6; i++) drive(0, i[0] ? 1'b0 : 1'b1, 0);
        waitn(LAT + 1);
        chk(hold_active == 1, "R7 stays held", hold_active, 1);
        // R5 deferred exit
        drive(0, 1, 0); waitn(LAT + 1);
        drive(1, 1, 0); waitn(LAT + 2);
        chk(hold_active == 1, "R5 exit deferred", hold_active, 1);
        drive(1, 0, 0); waitn(LAT + 1);
        chk(hold_active == 0, "R4 exit", hold_active, 0);
        chk(so_oe_o == 1 && shift_en_o == 1, "R6 released", so_oe_o, 1);
        // R3 deferred entry
        drive(1, 1, 0); waitn(2);
        drive(0, 1, 0); waitn(LAT + 2);
        chk(hold_active == 0, "R3 entry deferred", hold_active, 0);
        drive(0, 0, 0); waitn(LAT + 1);
        chk(hold_active == 1, "R3 entry on sck low", hold_active, 1);
        // R11 cancelled exit
        drive(0, 1, 0); waitn(2);
        drive(1, 1, 0); waitn(LAT + 1);
        drive(0, 1, 0); waitn(LAT + 1);
        drive(0, 0, 0); waitn(LAT + 1);
        chk(hold_active == 1, "R11 exit cancelled", hold_active, 1);
        drive(1, 0, 0); waitn(LAT + 1);
        chk(hold_active == 0, "R4 exit again", hold_active, 0);
        // R10 cancelled entry
        drive(1, 1, 0); waitn(2);
        drive(0, 1, 0); waitn(LAT + 1);
        drive(1, 1, 0); waitn(LAT + 1);
        drive(1, 0, 0); waitn(LAT + 1);
        chk(hold_active == 0, "R10 entry cancelled", hold_active, 0);
        // R8 deselect during hold
        drive(0, 0, 0); waitn(LAT + 1);
        chk(hold_active == 1, "R8 setup", hold_active, 1);
        drive(0, 0, 1); waitn(LAT - 1);
        chk(hold_active == 1, "R8 before latency", hold_active, 1);
        waitn(1);
        chk(hold_active == 0 && hold_abort == 1, "R8 abort cycle", {hold_active, hold_abort}, 1);
        waitn(1);
        chk(hold_abort == 0, "R8 abort single", hold_abort, 0);
        waitn(4);
        chk(hold_active == 0, "R8 stays clear deselected", hold_active, 0);
        // R9 hold low at select time
        drive(0, 0, 0); waitn(LAT + 3);
        chk(hold_active == 0, "R9 level not edge", hold_active, 0);
        drive(1, 0, 1); waitn(LAT + 1);
        drive(0, 0, 1); waitn(LAT + 1);
        drive(0, 0, 0); waitn(LAT + 2);
        chk(hold_active == 0, "R9 fall while deselected", hold_active, 0);
        drive(1, 0, 0); waitn(LAT + 1);

        // random phase, checked by the reference model each cycle
        for (int i = 0; i < 4000; i++) begin
            logic h, s, c;
            h = hold_n; s = sck; c = cs_n;
            if ($urandom_range(2, 0) == 0)  s = ~s;
            if ($urandom_range(15, 0) == 0) h = ~h;
            if ($urandom_range(63, 0) == 0) c = ~c;
            drive(h, s, c);
            so_oe_i = 1'($urandom_range(1, 0));
            shift_en_i = 1'($urandom_range(1, 0));
        end
        waitn(2);
        finish_report();
    end
endmodule